// File: doc/BRIEF.md
# Hierarchical Reset Controller for a Bridge Device

This block turns five reset sources of falling rank into three active-low reset outputs for a bridge. The top rank is an asynchronous power-good input. Below it, in order, come an asynchronous active-low front-panel pin, a link-reset event delivered in-band as a one-cycle pulse, a software secondary-bus reset bit taken as a level, and a hot-plug pulse raised when a frequency-change command is written.

Each output covers a different reach of state:
- `sticky_rst_n_o` guards state that must survive every reset except loss of power.
- `core_rst_n_o` guards the bridge core.
- `sec_bus_rst_n_o` drives the reset pin of the secondary bus.

Power-good and the panel pin assert their resets at once, without waiting for a clock. Their release passes through a chain of synchronising flops on `clk`. After power-good rises, the secondary-bus output stays low for a hold time. That time is set in microseconds and converted to clock cycles from the clock frequency. The three lower classes stretch their effect over parameterised minimum widths. Each class reaches less state than the class above it.

Top module: `rsth_ctrl`

## Requirements
- R1: While `pwr_good_i` is low, all three outputs are low, and they drop without waiting for a clock edge.
- R2: `sticky_rst_n_o` goes high on the second rising edge of `clk` that samples `pwr_good_i` high. After that it stays high whatever the panel, link, software and hot-plug inputs do.
- R3: While `panel_rst_n_i` is low, `core_rst_n_o` and `sec_bus_rst_n_o` are low at once and `sticky_rst_n_o` is unaffected. Both outputs go high again two edges after the pin returns high.
- R4: After a power-good rise, `sec_bus_rst_n_o` stays low for HOLD_CYCLES = (CLK_HZ/1e6)*HOLD_US cycles beyond the sticky release. It is therefore low for HOLD_CYCLES+1 cycles after the first edge. A panel reset does not restart this hold; a new power-good rise does.
- R5: A `link_rst_evt_i` pulse sampled on edge k drives `core_rst_n_o` and `sec_bus_rst_n_o` low from edge k for LINK_PULSE cycles. `sticky_rst_n_o` is untouched.
- R6: A rise of `sw_bus_rst_i` that is held for L sampling edges drives `sec_bus_rst_n_o` low for max(L, BUS_PULSE) cycles. The core and sticky outputs stay high.
- R7: A one-cycle `hp_freq_chg_i` pulse drives `sec_bus_rst_n_o` low for BUS_PULSE cycles. A new pulse while the output is low restarts that width. The core output stays high.
- R8: When sources overlap, each output is low in exactly the union of the cycles each source alone would hold it low.
- R9: A panel or power-good reset cancels pending link, software and hot-plug stretches. A link event that arrives while the core reset is held is ignored.
- R10: Rank is preserved at every cycle: a low sticky output implies a low core output, and a low core output implies a low bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwr_good_i | input | 1 | Power stable, asynchronous, high when good |
| panel_rst_n_i | input | 1 | Front-panel reset, asynchronous, active low |
| link_rst_evt_i | input | 1 | One-cycle pulse: in-band link reset received |
| sw_bus_rst_i | input | 1 | Software secondary-bus reset bit (level) |
| hp_freq_chg_i | input | 1 | One-cycle pulse: frequency-change command written |
| sticky_rst_n_o | output | 1 | Sticky-domain reset, active low |
| core_rst_n_o | output | 1 | Core-logic reset, active low |
| sec_bus_rst_n_o | output | 1 | Secondary-bus reset pin, active low |

## Verification
Two functions can land in the same cycle: the link stretch, which holds both core and bus, and the bus stretch started by a hot-plug pulse or a software bit. The bench fires a hot-plug pulse and a link event at offsets from zero to eight cycles apart. It also overlaps a software level with a later hot-plug pulse. In every case it counts the cycles each output spends low and compares that count with the size of the union of the single-source windows, computed arithmetically. A panel reset that lands in the middle of a bus stretch is judged by whether the bus output comes back two edges after the pin is released, rather than when the stretch would have ended.

// File: rtl/rsth_pkg.sv
package rsth_pkg;

   // Bits needed for a counter that must hold the value n.
   function automatic int unsigned cnt_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // Bundle of the three reset outputs, one per domain.
   typedef struct packed {
      logic sticky_n;
      logic core_n;
      logic bus_n;
   } rst_out_t;

endpackage

// File: rtl/rsth_sync.sv
// Asynchronous assertion, clock-synchronous release of one reset.
module rsth_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rel_n_o
);
   logic [STAGES-1:0] q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rsth_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) q <= '0;
      else         q <= {q[STAGES-2:0], 1'b1};
   end

   assign rel_n_o = q[STAGES-1];
endmodule

// File: rtl/rsth_stretch.sv
// Holds active_o for LEN cycles after each trigger; a trigger reloads the count.
module rsth_stretch
   import rsth_pkg::*;
#(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active_o
);
   localparam int unsigned W = cnt_width(LEN);
   localparam logic [W-1:0] LOAD = W'(LEN);

   logic [W-1:0] cnt;

   generate
      if (LEN < 1) begin : g_bad_len
         $error("rsth_stretch: LEN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (trig)       cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign active_o = (cnt != '0);
endmodule

// File: rtl/rsth_hold.sv
// Counts CYCLES clock cycles after release of rst_n, then raises done_o.
module rsth_hold
   import rsth_pkg::*;
#(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic done_o
);
   localparam int unsigned W = cnt_width(CYCLES);
   localparam logic [W-1:0] LAST = W'(CYCLES);

   logic [W-1:0] cnt;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("rsth_hold: CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (cnt != LAST)  cnt <= cnt + 1'b1;
   end

   assign done_o = (cnt == LAST);
endmodule

// File: rtl/rsth_ctrl.sv
module rsth_ctrl
   import rsth_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int HOLD_US     = 2000,
   parameter int SYNC_STAGES = 2,
   parameter int BUS_PULSE   = 8,
   parameter int LINK_PULSE  = 4
) (
   input  logic clk,
   input  logic pwr_good_i,
   input  logic panel_rst_n_i,
   input  logic link_rst_evt_i,
   input  logic sw_bus_rst_i,
   input  logic hp_freq_chg_i,
   output logic sticky_rst_n_o,
   output logic core_rst_n_o,
   output logic sec_bus_rst_n_o
);
   localparam int HOLD_CYCLES = (CLK_HZ / 1_000_000) * HOLD_US;

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("rsth_ctrl: CLK_HZ and HOLD_US give a zero hold time");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rsth_ctrl: SYNC_STAGES must be at least 2");
      end
      if (BUS_PULSE < 1 || LINK_PULSE < 1) begin : g_bad_pulse
         $error("rsth_ctrl: pulse widths must be at least 1");
      end
   endgenerate

   logic     arst_core_n;
   logic     sticky_n;
   logic     core_base_n;
   logic     hold_done;
   logic     sw_q;
   logic     bus_trig;
   logic     link_act;
   logic     bus_act;
   rst_out_t outs;

   // Power-good reaches every domain; the panel pin reaches core and below.
   assign arst_core_n = pwr_good_i & panel_rst_n_i;

   rsth_sync #(.STAGES(SYNC_STAGES)) u_sync_sticky (
      .clk     (clk),
      .arst_n  (pwr_good_i),
      .rel_n_o (sticky_n)
   );

   rsth_sync #(.STAGES(SYNC_STAGES)) u_sync_core (
      .clk     (clk),
      .arst_n  (arst_core_n),
      .rel_n_o (core_base_n)
   );

   // Bus hold time restarts only on power-good.
   rsth_hold #(.CYCLES(HOLD_CYCLES)) u_hold (
      .clk    (clk),
      .rst_n  (sticky_n),
      .done_o (hold_done)
   );

   always_ff @(posedge clk or negedge core_base_n) begin
      if (!core_base_n) sw_q <= 1'b0;
      else              sw_q <= sw_bus_rst_i;
   end

   assign bus_trig = (sw_bus_rst_i & ~sw_q) | hp_freq_chg_i;

   rsth_stretch #(.LEN(LINK_PULSE)) u_link (
      .clk      (clk),
      .rst_n    (core_base_n),
      .trig     (link_rst_evt_i),
      .active_o (link_act)
   );

   rsth_stretch #(.LEN(BUS_PULSE)) u_bus (
      .clk      (clk),
      .rst_n    (core_base_n),
      .trig     (bus_trig),
      .active_o (bus_act)
   );

   assign outs.sticky_n = sticky_n;
   assign outs.core_n   = core_base_n & ~link_act;
   assign outs.bus_n    = core_base_n & hold_done & ~link_act & ~bus_act & ~sw_q;

   assign sticky_rst_n_o  = outs.sticky_n;
   assign core_rst_n_o    = outs.core_n;
   assign sec_bus_rst_n_o = outs.bus_n;
endmodule

// File: rtl/rsth_ctrl_chk.sv
module rsth_ctrl_chk (
   input logic clk,
   input logic pwr_good_i,
   input logic panel_rst_n_i,
   input logic link_rst_evt_i,
   input logic sw_bus_rst_i,
   input logic hp_freq_chg_i,
   input logic sticky_rst_n_o,
   input logic core_rst_n_o,
   input logic sec_bus_rst_n_o
);
   AST_PWR_ALL_LOW: assert property (@(posedge clk)
      !pwr_good_i |-> (!sticky_rst_n_o && !core_rst_n_o && !sec_bus_rst_n_o)); // R1

   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!pwr_good_i)
      sticky_rst_n_o |=> sticky_rst_n_o); // R2

   AST_PANEL_LOW: assert property (@(posedge clk)
      !panel_rst_n_i |-> (!core_rst_n_o && !sec_bus_rst_n_o)); // R3

   AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!pwr_good_i)
      $rose(sticky_rst_n_o) |-> !sec_bus_rst_n_o); // R4

   AST_LINK_CORE: assert property (@(posedge clk) disable iff (!pwr_good_i || !panel_rst_n_i)
      (core_rst_n_o && link_rst_evt_i) |=> !core_rst_n_o); // R5

   AST_SW_BUS: assert property (@(posedge clk) disable iff (!pwr_good_i || !panel_rst_n_i)
      (core_rst_n_o && sw_bus_rst_i) |=> !sec_bus_rst_n_o); // R6

   AST_CORE_KEEP: assert property (@(posedge clk) disable iff (!pwr_good_i || !panel_rst_n_i)
      (core_rst_n_o && !link_rst_evt_i) |=> core_rst_n_o); // R6

   AST_HP_BUS: assert property (@(posedge clk) disable iff (!pwr_good_i || !panel_rst_n_i)
      (core_rst_n_o && hp_freq_chg_i) |=> !sec_bus_rst_n_o); // R7

   AST_RANK_STICKY: assert property (@(posedge clk) disable iff (!pwr_good_i)
      !sticky_rst_n_o |-> !core_rst_n_o); // R10
endmodule

bind rsth_ctrl rsth_ctrl_chk u_chk (
   .clk             (clk),
   .pwr_good_i      (pwr_good_i),
   .panel_rst_n_i   (panel_rst_n_i),
   .link_rst_evt_i  (link_rst_evt_i),
   .sw_bus_rst_i    (sw_bus_rst_i),
   .hp_freq_chg_i   (hp_freq_chg_i),
   .sticky_rst_n_o  (sticky_rst_n_o),
   .core_rst_n_o    (core_rst_n_o),
   .sec_bus_rst_n_o (sec_bus_rst_n_o)
);

// File: tb/rsth_ctrl_bench.sv
module rsth_ctrl_bench;
   localparam int CLK_HZ = 50_000_000;
   localparam int HOLD_US = 1;
   localparam int HOLD = (CLK_HZ / 1_000_000) * HOLD_US;
   localparam int P = 6;
   localparam int LK = 4;
   localparam int WIN = 80;

   logic clk = 1'b0;
   logic pwr_good_i, panel_rst_n_i, link_rst_evt_i, sw_bus_rst_i, hp_freq_chg_i;
   logic sticky_rst_n_o, core_rst_n_o, sec_bus_rst_n_o;
   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   rsth_ctrl #(.CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US), .SYNC_STAGES(2),
               .BUS_PULSE(P), .LINK_PULSE(LK)) u_rsth_ctrl (
      .clk(clk), .pwr_good_i(pwr_good_i), .panel_rst_n_i(panel_rst_n_i),
      .link_rst_evt_i(link_rst_evt_i), .sw_bus_rst_i(sw_bus_rst_i),
      .hp_freq_chg_i(hp_freq_chg_i), .sticky_rst_n_o(sticky_rst_n_o),
      .core_rst_n_o(core_rst_n_o), .sec_bus_rst_n_o(sec_bus_rst_n_o));

   task automatic check_eq(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit in_win(int t, int s, int len);
      return (s >= 0) && (t >= s) && (t < s + len);
   endfunction

   // Cycles in the union of up to three windows (start -1 means absent).
   function automatic int union_len(int s0, int l0, int s1, int l1, int s2, int l2);
      int n = 0;
      for (int t = 0; t < WIN; t++)
         if (in_win(t, s0, l0) || in_win(t, s1, l1) || in_win(t, s2, l2)) n++;
      return n;
   endfunction

   // Drive events at chosen cycle indices; count low cycles of each output.
   task automatic run_seq(int hp_at, int link_at, int sw_len,
                          output int st_low, output int co_low, output int bus_low);
      st_low = 0; co_low = 0; bus_low = 0;
      for (int i = 0; i <= WIN; i++) begin
         @(negedge clk);
         if (i > 0) begin
            if (!sticky_rst_n_o)  st_low++;
            if (!core_rst_n_o)    co_low++;
            if (!sec_bus_rst_n_o) bus_low++;
         end
         hp_freq_chg_i  = (i == hp_at);
         link_rst_evt_i = (i == link_at);
         sw_bus_rst_i   = (i < sw_len);
      end
      hp_freq_chg_i = 0; link_rst_evt_i = 0; sw_bus_rst_i = 0;
   endtask

   task automatic power_up_count(string tag);
      int st_low = 0, co_low = 0, bus_low = 0, rank_bad = 0;
      @(negedge clk);
      pwr_good_i = 1;
      for (int i = 0; i < HOLD + 10; i++) begin
         @(negedge clk);
         if (!sticky_rst_n_o)  st_low++;
         if (!core_rst_n_o)    co_low++;
         if (!sec_bus_rst_n_o) bus_low++;
         if ((!sticky_rst_n_o && core_rst_n_o) || (!core_rst_n_o && sec_bus_rst_n_o)) rank_bad++;
      end
      check_eq("R2", {tag, " sticky low cycles"}, st_low, 1);
      check_eq("R2", {tag, " core low cycles"}, co_low, 1);
      check_eq("R4", {tag, " bus hold cycles"}, bus_low, HOLD + 1);
      check_eq("R10", {tag, " rank violations"}, rank_bad, 0);
   endtask

   initial begin
      #4_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int st, co, bu, exp;
      pwr_good_i = 1; panel_rst_n_i = 1;
      link_rst_evt_i = 0; sw_bus_rst_i = 0; hp_freq_chg_i = 0;
      #2 pwr_good_i = 0;
      #3;
      // R1: reset state, before any clock edge
      check_eq("R1", "reset sticky", int'(sticky_rst_n_o), 0);
      check_eq("R1", "reset core", int'(core_rst_n_o), 0);
      check_eq("R1", "reset bus", int'(sec_bus_rst_n_o), 0);
      repeat (3) @(negedge clk);
      power_up_count("first power-up");

      // R6: software level swept over hold lengths
      for (int L = 1; L <= 10; L++) begin
         run_seq(-1, -1, L, st, co, bu);
         check_eq("R6", $sformatf("sw len %0d bus low", L), bu, (L > P) ? L : P);
         check_eq("R6", $sformatf("sw len %0d core low", L), co, 0);
         check_eq("R2", $sformatf("sw len %0d sticky low", L), st, 0);
      end

      // R7: hot-plug pulse alone
      run_seq(0, -1, 0, st, co, bu);
      check_eq("R7", "hp bus low", bu, P);
      check_eq("R7", "hp core low", co, 0);

      // R5: link event alone
      run_seq(-1, 0, 0, st, co, bu);
      check_eq("R5", "link core low", co, LK);
      check_eq("R5", "link bus low", bu, LK);
      check_eq("R2", "link sticky low", st, 0);

      // R8: hot-plug and link at offsets, including the same cycle
      for (int d = 0; d <= 8; d++) begin
         run_seq(0, d, 0, st, co, bu);
         check_eq("R8", $sformatf("hp+link d=%0d core", d), co, LK);
         check_eq("R8", $sformatf("hp+link d=%0d bus", d), bu, union_len(0, P, d, LK, -1, 0));
      end

      // R8 / R7: software level of 3 cycles, then hot-plug reload at d
      for (int d = 1; d <= 9; d += 4) begin
         run_seq(d, -1, 3, st, co, bu);
         exp = union_len(0, 3, 0, P, d, P);
         check_eq("R8", $sformatf("sw+hp d=%0d bus", d), bu, exp);
      end

      // R3 / R9: panel reset in the middle of a bus stretch
      @(negedge clk); hp_freq_chg_i = 1;
      @(negedge clk); hp_freq_chg_i = 0;
      @(negedge clk); #3 panel_rst_n_i = 0;
      #1;
      check_eq("R3", "panel core async", int'(core_rst_n_o), 0);
      check_eq("R3", "panel bus async", int'(sec_bus_rst_n_o), 0);
      check_eq("R3", "panel sticky kept", int'(sticky_rst_n_o), 1);
      @(negedge clk); link_rst_evt_i = 1;   // R9: ignored while panel held
      @(negedge clk); link_rst_evt_i = 0; panel_rst_n_i = 1;
      co = 0; bu = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!core_rst_n_o) co++;
         if (!sec_bus_rst_n_o) bu++;
      end
      check_eq("R9", "core low after panel release", co, 1);
      check_eq("R9", "bus low after panel release (stretch cancelled, no hold)", bu, 1);

      // R1: power drop during operation
      @(negedge clk); #3 pwr_good_i = 0;
      #1;
      check_eq("R1", "drop sticky async", int'(sticky_rst_n_o), 0);
      check_eq("R1", "drop core async", int'(core_rst_n_o), 0);
      check_eq("R1", "drop bus async", int'(sec_bus_rst_n_o), 0);

      // R4: power-good glitch during hold restarts the hold
      @(negedge clk); pwr_good_i = 1;
      repeat (10) @(negedge clk);
      #3 pwr_good_i = 0;
      repeat (2) @(negedge clk);
      power_up_count("repeat power-up");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule